// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave Engine

This block is the serial-side controller of a byte-addressed nonvolatile memory reached over a four-wire SPI link, with the storage modelled by an on-chip RAM. It oversamples chip select, serial clock, serial data in and a pause (hold) input with the system clock. It decodes an instruction byte followed, where needed, by a 16-bit address. It streams read data continuously and gathers write data into a one-page staging buffer. A write reaches the array only after a clean deselect, during an emulated self-timed busy period.

The status byte is assembled from the engine's own busy and write-enable flags plus six upper bits owned by a companion block. A new status value written over the link is handed to that companion as a one-cycle strobe. The companion also vetoes page writes to protected regions through a deny input, judged against the page address the engine presents.

Top module: `spi_mem_slave`

## Requirements
- R1: Bits travel most significant first. Input is captured on serial-clock rising edges and output changes on falling edges. Clock idle-low (mode 0) and idle-high (mode 3) are both accepted.
- R2: Instruction codes are 06h set write enable, 04h clear write enable, 05h read status, 01h write status, 03h read and 02h write. Any other code makes the rest of the selection be ignored.
- R3: The status byte is laid out as bit 0 busy, bit 1 write-enable latch, and bits 7:2 equal to `sr_upper_i`. It is resent for every further byte while selected.
- R4: Write-enable is set by 06h and cleared by 04h. Page writes and status writes run only while it is set. It clears when the busy period ends.
- R5: A read streams bytes from consecutive addresses. The 16-bit address wraps from FFFFh to 0000h. The array index is the low MEM_AW address bits.
- R6: Raising chip select at any bit position ends the current instruction, and the next selection decodes a fresh instruction.
- R7: During a page write the low log2(PAGE) address bits advance and wrap inside the page while the upper bits stay fixed. When more than PAGE bytes are sent, the last PAGE bytes win.
- R8: A page write commits only if chip select rises after a whole number of data bytes, with at least one byte. A trailing partial byte cancels it and leaves the write-enable latch unchanged.
- R9: A commit raises busy for BUSY_CYCLES clocks. While busy, every instruction except read status is ignored.
- R10: Hold takes effect and releases only while the serial clock is low. While held, clock edges are ignored and the output enable is low.
- R11: `miso_oe` is high only while read or status bytes are being shifted out.
- R12: `wr_deny_i` high at the deselect that would commit a page write cancels that write. `wr_addr_o` gives the page base address being written.
- R13: A status write of one whole byte pulses `sr_wr_o` with that byte on `sr_wr_data_o` and starts a busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for the miso driver |
| sr_upper_i | input | 6 | Status bits 7:2 from the companion block |
| sr_wr_o | output | 1 | One-cycle strobe carrying a new status value |
| sr_wr_data_o | output | 8 | Status value written over the link |
| wr_addr_o | output | 16 | Page base address of the pending page write |
| wr_deny_i | input | 1 | Companion veto of the pending page write |

## Verification
The array is filled page by page with an arithmetic pattern and read back in one sweep past the top of the array, which separates correct increment and aliasing from stuck or skipped addresses. A second read crosses the FFFFh wrap. Page writes that start near a page end, or that overflow a page, separate in-page wrap from carry into the upper address bits. Deselects at a byte boundary and mid-byte, with write-enable clear, with a deny, and during busy show which conditions gate a commit. Reads in both clock idle levels and across a hold pause show that edges are taken only when allowed.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam int ADDR_W = 16;

  localparam logic [7:0] OP_WEN   = 8'h06;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_STRD  = 8'h05;
  localparam logic [7:0] OP_STWR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    S_CMD, S_ADDR, S_RDATA, S_WDATA, S_STAT, S_SRIN, S_IGN
  } eng_st_t;
endpackage

// File: rtl/spi_mem_sampler.sv
module spi_mem_sampler (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic hold_n,
  output logic sel,
  output logic cs_rise,
  output logic rise,
  output logic fall,
  output logic din,
  output logic hold_act
);
  logic cs_q, cs_p, sck_q, sck_p, mosi_q, hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b1;
      cs_p   <= 1'b1;
      sck_q  <= 1'b0;
      sck_p  <= 1'b0;
      mosi_q <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      cs_p   <= cs_q;
      sck_q  <= sck;
      sck_p  <= sck_q;
      mosi_q <= mosi;
      hold_q <= hold_n;
    end
  end

  // pause state may only change while the serial clock is low
  always_ff @(posedge clk) begin
    if (rst || cs_q) hold_act <= 1'b0;
    else if (!sck_q) hold_act <= !hold_q;
  end

  assign sel     = !cs_q;
  assign cs_rise = cs_q && !cs_p;
  assign rise    = !cs_q && !hold_act && sck_q && !sck_p;
  assign fall    = !cs_q && !hold_act && !sck_q && sck_p;
  assign din     = mosi_q;
endmodule

// File: rtl/spi_mem_pagebuf.sv
module spi_mem_pagebuf #(
  parameter int PAGE = 128,
  parameter int PW   = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [PW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic          rmask
);
  logic [7:0]      pg_mem [PAGE];
  logic [PAGE-1:0] filled;

  always_ff @(posedge clk) begin
    if (we) pg_mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) filled <= '0;
    else if (we) filled[waddr] <= 1'b1;
  end

  assign rdata = pg_mem[raddr];
  assign rmask = filled[raddr];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int PAGE        = 128,
  parameter int BUSY_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              hold_n,
  output logic              miso,
  output logic              miso_oe,
  input  logic [5:0]        sr_upper_i,
  output logic              sr_wr_o,
  output logic [7:0]        sr_wr_data_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  input  logic              wr_deny_i
);
  localparam int PW  = $clog2(PAGE);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);
  localparam logic [BCW-1:0] BUSY_LOAD = BCW'(BUSY_CYCLES - 1);

  logic sel, cs_rise, rise, fall, din, hold_act;
  eng_st_t st;
  logic [2:0]        bitcnt;
  logic [7:0]        shin, opcode, sout, sr_byte;
  logic              abyte, got, sr_got, out_en, wel, busy;
  logic [ADDR_W-1:0] addr;
  logic [BCW-1:0]    bcnt;
  logic [PW:0]       cm_idx;

  logic [7:0]        new_byte, status, pb_rdata, mem_rdata;
  logic              byte_done, pb_we, pb_clr, pb_mask, rd_req, mem_we, cm_run;
  logic              wr_ok, sr_ok;
  logic [ADDR_W-1:0] rd_addr, cm_addr;

  spi_mem_sampler u_smp (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
    .sel(sel), .cs_rise(cs_rise), .rise(rise), .fall(fall), .din(din),
    .hold_act(hold_act)
  );

  assign new_byte  = {shin[6:0], din};
  assign byte_done = rise && (bitcnt == 3'd7);
  assign status    = {sr_upper_i, wel, busy};

  assign pb_we  = byte_done && (st == S_WDATA);
  assign pb_clr = byte_done && (st == S_CMD) && (new_byte == OP_WRITE) && !busy;

  spi_mem_pagebuf #(.PAGE(PAGE), .PW(PW)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .we(pb_we), .waddr(addr[PW-1:0]),
    .wdata(new_byte), .raddr(cm_idx[PW-1:0]), .rdata(pb_rdata), .rmask(pb_mask)
  );

  assign cm_run  = busy && !cm_idx[PW];
  assign mem_we  = cm_run && pb_mask;
  assign cm_addr = {addr[ADDR_W-1:PW], cm_idx[PW-1:0]};

  assign rd_req  = (byte_done && (st == S_ADDR) && abyte && (opcode == OP_READ)) ||
                   (fall && (st == S_RDATA) && (bitcnt == 3'd0));
  assign rd_addr = (st == S_ADDR) ? {addr[ADDR_W-9:0], new_byte} : addr + 1'b1;

  spi_mem_array #(.AW(MEM_AW)) u_arr (
    .clk(clk), .we(mem_we), .waddr(cm_addr[MEM_AW-1:0]), .wdata(pb_rdata),
    .re(rd_req), .raddr(rd_addr[MEM_AW-1:0]), .rdata(mem_rdata)
  );

  assign wr_addr_o = {addr[ADDR_W-1:PW], {PW{1'b0}}};
  assign wr_ok = (st == S_WDATA) && got && (bitcnt == 3'd0) && wel && !wr_deny_i && !busy;
  assign sr_ok = (st == S_SRIN) && sr_got && (bitcnt == 3'd0) && wel && !busy;
  assign miso  = sout[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_CMD;
      bitcnt       <= '0;
      shin         <= '0;
      opcode       <= '0;
      abyte        <= 1'b0;
      got          <= 1'b0;
      sr_got       <= 1'b0;
      sr_byte      <= '0;
      addr         <= '0;
      wel          <= 1'b0;
      busy         <= 1'b0;
      bcnt         <= '0;
      cm_idx       <= {1'b1, {PW{1'b0}}};
      sout         <= '0;
      out_en       <= 1'b0;
      miso_oe      <= 1'b0;
      sr_wr_o      <= 1'b0;
      sr_wr_data_o <= '0;
    end else begin
      sr_wr_o <= 1'b0;
      miso_oe <= out_en && !hold_act;

      if (busy) begin
        if (!cm_idx[PW]) cm_idx <= cm_idx + 1'b1;
        if (bcnt == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          bcnt <= bcnt - 1'b1;
        end
      end

      if (cs_rise) begin
        st     <= S_CMD;
        bitcnt <= '0;
        out_en <= 1'b0;
        if (wr_ok) begin
          busy   <= 1'b1;
          bcnt   <= BUSY_LOAD;
          cm_idx <= '0;
        end
        if (sr_ok) begin
          busy         <= 1'b1;
          bcnt         <= BUSY_LOAD;
          sr_wr_o      <= 1'b1;
          sr_wr_data_o <= sr_byte;
        end
      end else begin
        if (rise) begin
          bitcnt <= bitcnt + 1'b1;
          shin   <= new_byte;
          if (bitcnt == 3'd7) begin
            unique case (st)
              S_CMD: begin
                opcode <= new_byte;
                if (busy && new_byte != OP_STRD) begin
                  st <= S_IGN;
                end else begin
                  case (new_byte)
                    OP_WEN:   begin wel <= 1'b1; st <= S_IGN; end
                    OP_WDIS:  begin wel <= 1'b0; st <= S_IGN; end
                    OP_STRD:  st <= S_STAT;
                    OP_STWR:  begin st <= S_SRIN; sr_got <= 1'b0; end
                    OP_READ,
                    OP_WRITE: begin st <= S_ADDR; abyte <= 1'b0; got <= 1'b0; end
                    default:  st <= S_IGN;
                  endcase
                end
              end
              S_ADDR: begin
                addr  <= {addr[ADDR_W-9:0], new_byte};
                abyte <= 1'b1;
                if (abyte) st <= (opcode == OP_READ) ? S_RDATA : S_WDATA;
              end
              S_WDATA: begin
                addr <= {addr[ADDR_W-1:PW], PW'(addr[PW-1:0] + 1'b1)};
                got  <= 1'b1;
              end
              S_SRIN: begin
                if (!sr_got) begin
                  sr_byte <= new_byte;
                  sr_got  <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end

        if (fall && (st == S_RDATA || st == S_STAT)) begin
          if (bitcnt == 3'd0) begin
            out_en <= 1'b1;
            if (st == S_STAT) begin
              sout <= status;
            end else begin
              sout <= mem_rdata;
              addr <= addr + 1'b1;
            end
          end else begin
            sout <= {sout[6:0], 1'b0};
          end
        end
      end
    end
  end

  p_oe_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!sel && $past(!sel) && $past(!sel, 2)) |-> !miso_oe);

  p_hold_hiz_r10: assert property (@(posedge clk) disable iff (rst)
    hold_act |=> !miso_oe);

  p_commit_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_wel_at_end_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  p_srwr_busy_r13: assert property (@(posedge clk) disable iff (rst)
    sr_wr_o |-> busy);

  p_no_cmd_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(addr[ADDR_W-1:PW]));
endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
  localparam int MAW  = 9;
  localparam int PG   = 128;
  localparam int BUSY = 1500;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe, sr_wr_o, wr_deny_i = 1'b0;
  logic [7:0]  sr_wr_data_o;
  logic [5:0]  sr_upper_i = 6'h00;
  logic [15:0] wr_addr_o;

  int nchk = 0, nfail = 0, sr_cnt = 0;
  logic [7:0] sr_last = 8'h00;
  bit idle_hi = 1'b0, done = 1'b0, oe_seen = 1'b0;
  logic [7:0] model [0:511];
  logic [7:0] wbuf  [0:255];
  logic [7:0] rbuf  [0:599];

  always #2 clk = ~clk;

  spi_mem_slave #(.MEM_AW(MAW), .PAGE(PG), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .hold_n(hold_n),
    .miso(miso), .miso_oe(miso_oe), .sr_upper_i(sr_upper_i), .sr_wr_o(sr_wr_o),
    .sr_wr_data_o(sr_wr_data_o), .wr_addr_o(wr_addr_o), .wr_deny_i(wr_deny_i)
  );

  always @(posedge clk) if (sr_wr_o) begin sr_cnt++; sr_last = sr_wr_data_o; end
  always @(negedge clk) if (miso_oe) oe_seen = 1'b1;

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 37 + 11 + salt) ^ (a >> 5));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sel_begin();
    sck = idle_hi;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_end();
    if (!idle_hi) begin sck = 1'b0; repeat (HALF) @(negedge clk); end
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; mosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    xbits(b, 8, r);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    sel_begin(); xfer(op, r); sel_end();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel_begin(); xfer(8'h05, r); xfer(8'h00, s); sel_end();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int g = 0;
    do begin rdsr(s); g++; end while (s[0] && g < 60);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input bit upd);
    logic [7:0] r;
    logic [15:0] wa;
    sel_begin();
    xfer(8'h02, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(wbuf[k], r);
    sel_end();
    if (upd) for (int k = 0; k < n; k++) begin
      wa = {a[15:7], 7'(a[6:0] + 7'(k))};
      model[wa[8:0]] = wbuf[k];
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic [7:0] r;
    sel_begin();
    xfer(8'h03, r); xfer(a[15:8], r); xfer(a[7:0], r);
    for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
    sel_end();
  endtask

  task automatic cmp_read(input string req, input logic [15:0] a, input int n);
    logic [15:0] ra;
    do_read(a, n);
    for (int k = 0; k < n; k++) begin
      ra = a + 16'(k);
      chk(req, {24'h0, rbuf[k]}, {24'h0, model[ra[8:0]]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r;
    int c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R11 reset state, R3 status layout
    chk("R11 reset oe", {31'h0, miso_oe}, 32'h0);
    rdsr(s);
    chk("R3 reset status", {24'h0, s}, 32'h00);
    sr_upper_i = 6'h2A;
    op1(8'h06);
    rdsr(s);
    chk("R3 R4 wel set", {24'h0, s}, {24'h0, 6'h2A, 2'b10});
    op1(8'h04);
    rdsr(s);
    chk("R4 wel clear", {24'h0, s}, {24'h0, 6'h2A, 2'b00});
    sr_upper_i = 6'h00;

    // R4 write with latch clear does nothing (no busy)
    for (int k = 0; k < 4; k++) wbuf[k] = 8'h55;
    do_write(16'h0000, 4, 1'b0);
    rdsr(s);
    chk("R4 no wel no busy", {24'h0, s}, 32'h0);

    // fill all pages; R9 busy seen, R4 latch cleared after
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < PG; k++) wbuf[k] = pat(p * PG + k, 0);
      op1(8'h06);
      do_write(16'(p * PG), PG, 1'b1);
      rdsr(s);
      chk("R9 busy after commit", {31'h0, s[0]}, 32'h1);
      wait_idle();
      rdsr(s);
      chk("R4 wel cleared at end", {24'h0, s}, 32'h0);
    end

    // R5 R1 full sweep past array top
    cmp_read("R5 R1 sweep", 16'h0000, 514);
    // R5 16-bit wrap
    cmp_read("R5 wrap FFFF", 16'hFFFF, 3);

    // R7 wrap inside page
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
    op1(8'h06);
    do_write(16'h017E, 4, 1'b1);
    wait_idle();
    cmp_read("R7 page wrap", 16'h0100, 128);
    cmp_read("R7 next page intact", 16'h0180, 2);

    // R7 overflow: last PAGE bytes kept
    for (int k = 0; k < 130; k++) wbuf[k] = pat(k, 99);
    op1(8'h06);
    do_write(16'h0185, 130, 1'b1);
    wait_idle();
    cmp_read("R7 overflow", 16'h0180, 128);

    // R8 partial final byte cancels, wel kept
    op1(8'h06);
    sel_begin();
    xfer(8'h02, r); xfer(8'h00, r); xfer(8'h10, r); xfer(8'hEE, r); xbits(8'hEE, 5, r);
    sel_end();
    rdsr(s);
    chk("R8 partial no busy wel kept", {24'h0, s}, 32'h02);
    cmp_read("R8 data unchanged", 16'h0010, 2);

    // R12 deny blocks commit, address presented
    wr_deny_i = 1'b1;
    for (int k = 0; k < 2; k++) wbuf[k] = 8'h3C;
    do_write(16'h00C5, 2, 1'b0);
    chk("R12 page base", {16'h0, wr_addr_o}, 32'h0080);
    rdsr(s);
    chk("R12 denied no busy", {31'h0, s[0]}, 32'h0);
    wr_deny_i = 1'b0;
    cmp_read("R12 data unchanged", 16'h00C5, 2);

    // R13 status write
    c0 = sr_cnt;
    sel_begin(); xfer(8'h01, r); xfer(8'hA5, r); sel_end();
    chk("R13 strobe count", sr_cnt, c0 + 1);
    chk("R13 strobe data", {24'h0, sr_last}, 32'hA5);
    rdsr(s);
    chk("R13 busy", {31'h0, s[0]}, 32'h1);
    // R9 during busy: read ignored, write ignored
    oe_seen = 1'b0;
    sel_begin(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h20, r); xfer(8'h00, r); sel_end();
    chk("R9 read ignored busy", {31'h0, oe_seen}, 32'h0);
    wbuf[0] = 8'h77;
    do_write(16'h0020, 1, 1'b0);
    wait_idle();
    cmp_read("R9 write ignored busy", 16'h0020, 1);
    c0 = sr_cnt;
    sel_begin(); xfer(8'h01, r); xfer(8'h5A, r); sel_end();
    chk("R13 no wel no strobe", sr_cnt, c0);

    // R2 unknown opcode ignored
    oe_seen = 1'b0;
    sel_begin(); xfer(8'hAB, r); xfer(8'h00, r); xfer(8'h00, r); sel_end();
    chk("R2 unknown opcode", {31'h0, oe_seen}, 32'h0);

    // R6 read cut mid-byte, fresh decode next
    sel_begin(); xfer(8'h03, r); xfer(8'h00, r); xfer(8'h40, r); xfer(8'h00, r);
    xbits(8'h00, 3, r); sel_end();
    rdsr(s);
    chk("R6 fresh decode", {24'h0, s}, 32'h0);

    // R10 hold pause in a read
    sel_begin();
    xfer(8'h03, r); xfer(8'h00, r); xfer(8'h50, r);
    xfer(8'h00, r);
    chk("R10 byte before hold", {24'h0, r}, {24'h0, model[9'h050]});
    sck = 1'b0; repeat (HALF) @(negedge clk);
    hold_n = 1'b0; repeat (HALF) @(negedge clk);
    chk("R10 oe low in hold", {31'h0, miso_oe}, 32'h0);
    for (int t = 0; t < 4; t++) begin
      sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    chk("R10 oe still low", {31'h0, miso_oe}, 32'h0);
    hold_n = 1'b1; repeat (HALF) @(negedge clk);
    chk("R11 oe back", {31'h0, miso_oe}, 32'h1);
    xfer(8'h00, r);
    chk("R10 byte after hold", {24'h0, r}, {24'h0, model[9'h051]});
    sel_end();
    chk("R11 oe off after deselect", {31'h0, miso_oe}, 32'h0);

    // R1 mode 3 read and write
    idle_hi = 1'b1;
    cmp_read("R1 mode3 read", 16'h01F0, 20);
    for (int k = 0; k < 3; k++) wbuf[k] = 8'hC0 + 8'(k);
    op1(8'h06);
    do_write(16'h0033, 3, 1'b1);
    wait_idle();
    cmp_read("R1 mode3 write", 16'h0032, 5);
    idle_hi = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule